// File: doc/BRIEF.md
# Charge-Transfer Pulse Sequencer

This block runs one capacitive-touch acquisition. It generates a train of charge-transfer pulses, each with a high phase and a low phase, and counts the completed pulses. The run ends in one of two ways. Either an external comparator reports that the sense capacitor has crossed its threshold, or the count reaches a power-of-two-minus-one ceiling, which ends the run with an error. Every phase length is measured in system clock cycles. The lengths are scaled by a programmable power-of-two prescaler. The high phase can also be stretched by a spread-spectrum term that changes from pulse to pulse, which spreads the emitted energy over more frequencies.

Software arms a run by setting a start bit. The block clears that bit itself when the run ends, and software can clear it early to cancel the run. In synchronized mode the first pulse waits for an event on a sync input of selectable polarity. Between runs, the shared sensing I/Os are either driven low or released to float. During a run they are driven by the pulse train. The final count stays readable until the next start. The error flag is sticky until the next start, and a one-cycle strobe marks every normal finish.

Top module: `ctseq_top`

## Requirements
- R1: While `ctl_en` is 0, `start_set` is ignored, and `io_float_o` is 1. Dropping `ctl_en` during a run aborts it on the next edge: `pulse_o` and `start_o` go to 0 and `eoa_o` stays 0.
- R2: The low phase lasts (`lo_len`+1)·2^`pg_div_sel` clock cycles. Without spread, the high phase lasts (`hi_len`+1)·2^`pg_div_sel` cycles. `pulse_o` is 1 exactly during high phases.
- R3: With `ss_en`=1, each high phase gains (v+1)·(`ss_div_sel`?2:1) cycles. Here v is the value, taken as the phase is entered, of a sweep counter. The sweep counter starts at 0 on reset. It advances on every cycle when `ss_div_sel`=0 and on every second cycle when `ss_div_sel`=1. It steps by 1 and returns to 0 from any value ≥ `ss_dev`.
- R4: A `start_set` pulse accepted while idle and enabled sets `start_o` one edge later. The block clears `start_o` at the end of a run. `start_cancel` clears it and returns the block to idle with no `eoa_o`.
- R5: The pulse ceiling is 2^(8+s)−1, where s is `maxcnt_sel` and codes above 6 count as 6. Completing the ceiling-th pair ends the run with `mce_o`=1. `mce_o` stays set until the next accepted start clears it.
- R6: `count_o` is cleared when a start is accepted. It increments by one at the end of each completed low phase. It holds its value after the run ends or is cancelled.
- R7: `eoa_o` is a one-cycle strobe, asserted on the edge on which a run ends by threshold or by ceiling.
- R8: In synchronized mode (`sync_mode`=1), the first high phase begins only on a sync event. With `sync_pol`=0 the event is a falling edge of `sync_in` between two samples. With `sync_pol`=1 it is `sync_in` being high. The first pulse begins on the edge that sees the event.
- R9: When enabled and not in a pulse phase, `io_float_o` follows `idle_float` (1 = float, 0 = drive low). During high and low phases it is 0.
- R10: `thresh_hit` sampled high during a high or low phase ends the run on that edge. The unfinished pair is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable |
| start_set | input | 1 | Request to set the start bit (one cycle) |
| start_cancel | input | 1 | Clear the start bit and abort the run |
| sync_mode | input | 1 | 1 = wait for a sync event before the first pulse |
| sync_pol | input | 1 | 0 = falling edge, 1 = high level |
| sync_in | input | 1 | Synchronization input |
| idle_float | input | 1 | Idle I/O mode: 1 float, 0 drive low |
| maxcnt_sel | input | MC_SEL_W | Pulse ceiling select |
| pg_div_sel | input | PG_SEL_W | Phase prescaler exponent |
| ss_div_sel | input | 1 | Spread clock divide: 0 = /1, 1 = /2 |
| ss_en | input | 1 | Spread-spectrum enable |
| ss_dev | input | DEV_W | Spread sweep upper bound |
| hi_len | input | LEN_W | High phase length minus one |
| lo_len | input | LEN_W | Low phase length minus one |
| thresh_hit | input | 1 | Comparator threshold reached |
| pulse_o | output | 1 | Charge-transfer pulse |
| io_float_o | output | 1 | 1 = sensing I/Os released to float |
| start_o | output | 1 | Start bit state |
| eoa_o | output | 1 | End-of-acquisition strobe |
| mce_o | output | 1 | Sticky ceiling-error flag |
| count_o | output | CNT_W | Completed pulse count |

## Verification
Every result except `io_float_o` shows up on the first edge that sees its cause. The start bit, the reset of the count and the error flag appear one edge after the accepted `start_set`. A non-synchronized run enters its first high phase one edge after that. A sync event, a threshold hit or a cancel acts on the edge that samples it. `io_float_o` is combinational in `ctl_en` and `idle_float`. The bench drives its inputs just after a rising edge and compares every output at the following falling edge with a behavioural model. That model steps the same edge-by-edge rules using integers. Directed checks measure phase widths by counting falling-edge samples of `pulse_o`, and they read the count at the cycle where `eoa_o` is seen.

// File: rtl/ctseq_pkg.sv
package ctseq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_SYNC = 2'd1,
      SEQ_HIGH = 2'd2,
      SEQ_LOW  = 2'd3
   } seq_state_e;

   // Longest phase in cycles for the given field widths.
   function automatic int unsigned worst_phase(input int unsigned len_w,
                                               input int unsigned pg_sel_w,
                                               input int unsigned dev_w);
      return ((2 ** len_w) << ((2 ** pg_sel_w) - 1)) + ((2 ** dev_w) << 1);
   endfunction

endpackage

// File: rtl/ctseq_limit.sv
module ctseq_limit #(
   parameter int SEL_W    = 3,
   parameter int BASE_LOG = 8,
   parameter int STEPS    = 7,
   parameter int CNT_W    = 14
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] ceiling
);
   always_comb begin
      ceiling = '0;
      for (int i = 0; i < STEPS; i++) begin
         if ((int'(sel) == i) || ((i == STEPS - 1) && (int'(sel) > i)))
            ceiling = CNT_W'((64'(1) << (BASE_LOG + i)) - 64'(1));
      end
   end
endmodule

// File: rtl/ctseq_spread.sv
module ctseq_spread #(
   parameter bit HAS_SPREAD = 1'b1,
   parameter int DEV_W      = 7,
   parameter int PH_W       = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ss_en,
   input  logic             ss_div_sel,
   input  logic [DEV_W-1:0] ss_dev,
   output logic [PH_W-1:0]  ext_cycles
);
   generate
      if (HAS_SPREAD) begin : g_sweep
         logic             tog_q;
         logic [DEV_W-1:0] sweep_q;
         logic             ss_tick;

         assign ss_tick = !ss_div_sel || tog_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tog_q   <= 1'b0;
               sweep_q <= '0;
            end else begin
               tog_q <= !tog_q;
               if (ss_tick)
                  sweep_q <= (sweep_q >= ss_dev) ? '0 : sweep_q + 1'b1;
            end
         end

         assign ext_cycles = ss_en
                             ? ((PH_W'(sweep_q) + PH_W'(1)) << ss_div_sel)
                             : '0;
      end else begin : g_flat
         logic unused_spread;
         assign unused_spread = ^{clk, rst_n, ss_en, ss_div_sel, ss_dev};
         assign ext_cycles    = '0;
      end
   endgenerate
endmodule

// File: rtl/ctseq_sync_det.sv
module ctseq_sync_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic sync_pol,
   output logic sync_ev
);
   logic sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= sync_in;
   end

   assign sync_ev = sync_pol ? sync_in : (sync_q && !sync_in);
endmodule

// File: rtl/ctseq_phase_timer.sv
module ctseq_phase_timer #(
   parameter int PH_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PH_W-1:0] load_val,
   output logic            last
);
   logic [PH_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (load)           left_q <= load_val;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign last = (left_q == PH_W'(1));
endmodule

// File: rtl/ctseq_top.sv
module ctseq_top #(
   parameter bit HAS_SPREAD  = 1'b1,
   parameter int LEN_W       = 4,
   parameter int DEV_W       = 7,
   parameter int PG_SEL_W    = 3,
   parameter int MC_SEL_W    = 3,
   parameter int MC_BASE_LOG = 8,
   parameter int MC_STEPS    = 7,
   parameter int CNT_W       = MC_BASE_LOG + MC_STEPS - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_en,
   input  logic                start_set,
   input  logic                start_cancel,
   input  logic                sync_mode,
   input  logic                sync_pol,
   input  logic                sync_in,
   input  logic                idle_float,
   input  logic [MC_SEL_W-1:0] maxcnt_sel,
   input  logic [PG_SEL_W-1:0] pg_div_sel,
   input  logic                ss_div_sel,
   input  logic                ss_en,
   input  logic [DEV_W-1:0]    ss_dev,
   input  logic [LEN_W-1:0]    hi_len,
   input  logic [LEN_W-1:0]    lo_len,
   input  logic                thresh_hit,
   output logic                pulse_o,
   output logic                io_float_o,
   output logic                start_o,
   output logic                eoa_o,
   output logic                mce_o,
   output logic [CNT_W-1:0]    count_o
);
   import ctseq_pkg::*;

   localparam int unsigned WORST = worst_phase(LEN_W, PG_SEL_W, DEV_W);
   localparam int          PH_W  = $clog2(WORST + 1);

   initial begin
      if (CNT_W < MC_BASE_LOG + MC_STEPS - 1)
         $fatal(1, "ctseq_top: CNT_W too small for the largest ceiling");
      if (MC_STEPS > (2 ** MC_SEL_W))
         $fatal(1, "ctseq_top: MC_STEPS exceeds the select range");
      if (LEN_W < 1 || DEV_W < 1 || PG_SEL_W < 1)
         $fatal(1, "ctseq_top: field widths must be positive");
   end

   seq_state_e      st_q, st_d;
   logic            start_q;
   logic            eoa_q;
   logic            mce_q;
   logic [CNT_W-1:0] count_q;

   logic [CNT_W-1:0] ceiling;
   logic [CNT_W-1:0] count_nx;
   logic [PH_W-1:0]  ext_cycles;
   logic [PH_W-1:0]  hi_load;
   logic [PH_W-1:0]  lo_load;
   logic [PH_W-1:0]  tmr_val;
   logic             tmr_load;
   logic             tmr_last;
   logic             sync_ev;
   logic             abort;
   logic             accept;
   logic             finish;
   logic             ceil_err;
   logic             pair_done;

   ctseq_limit #(
      .SEL_W   (MC_SEL_W),
      .BASE_LOG(MC_BASE_LOG),
      .STEPS   (MC_STEPS),
      .CNT_W   (CNT_W)
   ) u_limit (
      .sel    (maxcnt_sel),
      .ceiling(ceiling)
   );

   ctseq_spread #(
      .HAS_SPREAD(HAS_SPREAD),
      .DEV_W     (DEV_W),
      .PH_W      (PH_W)
   ) u_spread (
      .clk       (clk),
      .rst_n     (rst_n),
      .ss_en     (ss_en),
      .ss_div_sel(ss_div_sel),
      .ss_dev    (ss_dev),
      .ext_cycles(ext_cycles)
   );

   ctseq_sync_det u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_in),
      .sync_pol(sync_pol),
      .sync_ev (sync_ev)
   );

   ctseq_phase_timer #(
      .PH_W(PH_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .last    (tmr_last)
   );

   assign lo_load  = (PH_W'(lo_len) + PH_W'(1)) << pg_div_sel;
   assign hi_load  = ((PH_W'(hi_len) + PH_W'(1)) << pg_div_sel) + ext_cycles;
   assign count_nx = count_q + 1'b1;
   assign abort    = !ctl_en || start_cancel;
   assign accept   = start_set && !abort && !start_q;

   always_comb begin
      st_d      = st_q;
      tmr_load  = 1'b0;
      tmr_val   = hi_load;
      finish    = 1'b0;
      ceil_err  = 1'b0;
      pair_done = 1'b0;
      unique case (st_q)
         SEQ_IDLE: begin
            if (start_q && !abort) begin
               if (sync_mode) begin
                  st_d = SEQ_SYNC;
               end else begin
                  st_d     = SEQ_HIGH;
                  tmr_load = 1'b1;
               end
            end
         end
         SEQ_SYNC: begin
            if (abort) begin
               st_d = SEQ_IDLE;
            end else if (sync_ev) begin
               st_d     = SEQ_HIGH;
               tmr_load = 1'b1;
            end
         end
         SEQ_HIGH: begin
            if (abort) begin
               st_d = SEQ_IDLE;
            end else if (thresh_hit) begin
               st_d   = SEQ_IDLE;
               finish = 1'b1;
            end else if (tmr_last) begin
               st_d     = SEQ_LOW;
               tmr_load = 1'b1;
               tmr_val  = lo_load;
            end
         end
         SEQ_LOW: begin
            if (abort) begin
               st_d = SEQ_IDLE;
            end else if (thresh_hit) begin
               st_d   = SEQ_IDLE;
               finish = 1'b1;
            end else if (tmr_last) begin
               pair_done = 1'b1;
               if (count_nx == ceiling) begin
                  st_d     = SEQ_IDLE;
                  finish   = 1'b1;
                  ceil_err = 1'b1;
               end else begin
                  st_d     = SEQ_HIGH;
                  tmr_load = 1'b1;
               end
            end
         end
         default: st_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         start_q <= 1'b0;
         eoa_q   <= 1'b0;
         mce_q   <= 1'b0;
         count_q <= '0;
      end else begin
         st_q  <= st_d;
         eoa_q <= finish;
         if (abort || finish) start_q <= 1'b0;
         else if (accept)     start_q <= 1'b1;
         if (accept) begin
            count_q <= '0;
            mce_q   <= 1'b0;
         end else begin
            if (pair_done) count_q <= count_nx;
            if (ceil_err)  mce_q   <= 1'b1;
         end
      end
   end

   assign pulse_o    = (st_q == SEQ_HIGH);
   assign io_float_o = !ctl_en ? 1'b1
                     : ((st_q == SEQ_HIGH) || (st_q == SEQ_LOW)) ? 1'b0
                     : idle_float;
   assign start_o    = start_q;
   assign eoa_o      = eoa_q;
   assign mce_o      = mce_q;
   assign count_o    = count_q;

endmodule

// File: rtl/ctseq_checker.sv
module ctseq_checker #(
   parameter int CNT_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_en,
   input logic             start_cancel,
   input logic             thresh_hit,
   input logic             pulse_o,
   input logic             io_float_o,
   input logic             start_o,
   input logic             eoa_o,
   input logic             mce_o,
   input logic [CNT_W-1:0] count_o
);
   AST_DISABLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> (!pulse_o && !start_o)); // R1

   AST_PULSE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> start_o); // R4

   AST_CANCEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      start_cancel |=> (!start_o && !eoa_o)); // R4

   AST_END_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n)
      eoa_o |-> !start_o); // R4

   AST_ERR_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mce_o) |-> eoa_o); // R5

   AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o != $past(count_o)) |-> ((count_o == $past(count_o) + 1'b1) || (count_o == '0))); // R6

   AST_EOA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eoa_o |=> !eoa_o); // R7

   AST_RUN_DRIVES_IO: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> !io_float_o); // R9

   AST_THRESH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o && thresh_hit && ctl_en && !start_cancel) |=> (eoa_o && !pulse_o)); // R10
endmodule

bind ctseq_top ctseq_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_en      (ctl_en),
   .start_cancel(start_cancel),
   .thresh_hit  (thresh_hit),
   .pulse_o     (pulse_o),
   .io_float_o  (io_float_o),
   .start_o     (start_o),
   .eoa_o       (eoa_o),
   .mce_o       (mce_o),
   .count_o     (count_o)
);

// File: tb/sim_ctseq_top.sv
`timescale 1ns/1ps
module sim_ctseq_top;
   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_en = 0, start_set = 0, start_cancel = 0, sync_mode = 0, sync_pol = 0;
   logic sync_in = 0, idle_float = 0, ss_div_sel = 0, ss_en = 0, thresh_hit = 0;
   logic [2:0] maxcnt_sel = 0, pg_div_sel = 0;
   logic [6:0] ss_dev = 0;
   logic [3:0] hi_len = 0, lo_len = 0;
   logic pulse_o, io_float_o, start_o, eoa_o, mce_o;
   logic [13:0] count_o;

   int checks = 0, failures = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   ctseq_top u0 (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .start_set(start_set),
      .start_cancel(start_cancel), .sync_mode(sync_mode), .sync_pol(sync_pol),
      .sync_in(sync_in), .idle_float(idle_float), .maxcnt_sel(maxcnt_sel),
      .pg_div_sel(pg_div_sel), .ss_div_sel(ss_div_sel), .ss_en(ss_en),
      .ss_dev(ss_dev), .hi_len(hi_len), .lo_len(lo_len), .thresh_hit(thresh_hit),
      .pulse_o(pulse_o), .io_float_o(io_float_o), .start_o(start_o),
      .eoa_o(eoa_o), .mce_o(mce_o), .count_o(count_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: 0 idle, 1 waiting for sync, 2 high, 3 low.
   int m_st, m_rem, m_cnt, m_v, hi_n, lo_n, ceil, nst;
   bit m_start, m_mce, m_eoa, m_sq, m_tog, abort, ev, fin, err, acc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_rem = 0; m_cnt = 0; m_v = 0;
         m_start = 0; m_mce = 0; m_eoa = 0; m_sq = 0; m_tog = 0;
      end else begin
         hi_n  = (hi_len + 1) * (1 << pg_div_sel) + (ss_en ? (m_v + 1) * (ss_div_sel ? 2 : 1) : 0);
         lo_n  = (lo_len + 1) * (1 << pg_div_sel);
         ceil  = (256 << ((maxcnt_sel > 6) ? 6 : maxcnt_sel)) - 1;
         abort = !ctl_en || start_cancel;
         ev    = sync_pol ? sync_in : (m_sq && !sync_in);
         acc   = start_set && !abort && !m_start;
         fin = 0; err = 0; nst = m_st;
         case (m_st)
            0: if (m_start && !abort) begin
                  if (sync_mode) nst = 1;
                  else begin nst = 2; m_rem = hi_n; end
               end
            1: if (abort) nst = 0;
               else if (ev) begin nst = 2; m_rem = hi_n; end
            2: if (abort) nst = 0;
               else if (thresh_hit) begin nst = 0; fin = 1; end
               else if (m_rem == 1) begin nst = 3; m_rem = lo_n; end
               else m_rem--;
            default: if (abort) nst = 0;
               else if (thresh_hit) begin nst = 0; fin = 1; end
               else if (m_rem == 1) begin
                  m_cnt++;
                  if (m_cnt == ceil) begin nst = 0; fin = 1; err = 1; end
                  else begin nst = 2; m_rem = hi_n; end
               end else m_rem--;
         endcase
         if (abort || fin) m_start = 0;
         else if (acc) m_start = 1;
         if (acc) begin m_cnt = 0; m_mce = 0; end
         if (err) m_mce = 1;
         m_eoa = fin;
         m_st  = nst;
         if (!ss_div_sel || m_tog) m_v = (m_v >= ss_dev) ? 0 : m_v + 1;
         m_tog = !m_tog;
         m_sq  = sync_in;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2/R3 pulse_o vs model", pulse_o, (m_st == 2));
         chk("R4 start_o vs model", start_o, m_start);
         chk("R6 count_o vs model", count_o, m_cnt);
         chk("R7/R10 eoa_o vs model", eoa_o, m_eoa);
         chk("R5 mce_o vs model", mce_o, m_mce);
         chk("R9 io_float_o vs model", io_float_o,
             !ctl_en ? 1 : ((m_st >= 2) ? 0 : idle_float));
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic pulse_start();
      start_set = 1; tick(); start_set = 0;
   endtask

   task automatic cancel();
      start_cancel = 1; tick(); start_cancel = 0;
   endtask

   task automatic high_width(output int w);
      @(negedge clk);
      while (!pulse_o) @(negedge clk);
      w = 0;
      while (pulse_o) begin w++; @(negedge clk); end
   endtask

   task automatic wait_eoa(input int lim, output bit seen);
      seen = 0;
      for (int i = 0; i < lim && !seen; i++) begin
         @(negedge clk);
         if (eoa_o) seen = 1;
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired t=%0t", $time);
      finish_run();
   end

   initial begin
      int w, c;
      bit seen;
      repeat (3) tick();
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset io_float_o while disabled", io_float_o, 1);
      chk("R6 reset count_o", count_o, 0);
      chk("R4 reset start_o", start_o, 0);

      // R1: start ignored while disabled
      tick(); pulse_start(); repeat (2) tick();
      @(negedge clk);
      chk("R1 start ignored while disabled", start_o, 0);

      // R9: idle I/O mode
      ctl_en = 1; idle_float = 0; tick(); @(negedge clk);
      chk("R9 idle drive low", io_float_o, 0);
      idle_float = 1; tick(); @(negedge clk);
      chk("R9 idle float", io_float_o, 1);

      // R2: phase widths with prescaler
      hi_len = 2; lo_len = 1; pg_div_sel = 1; maxcnt_sel = 0;
      tick(); pulse_start();
      high_width(w);
      chk("R2 high width", w, 6);
      w = 0;
      while (!pulse_o) begin w++; @(negedge clk); end
      chk("R2 low width", w, 4);
      chk("R9 run drives io", io_float_o, 0);
      #1 thresh_hit = 1; tick(); thresh_hit = 0;
      @(negedge clk);
      chk("R10 eoa on threshold", eoa_o, 1);
      chk("R10 partial pair not counted", count_o, 1);
      chk("R4 start cleared at end", start_o, 0);
      tick(); @(negedge clk);
      chk("R7 eoa lasts one cycle", eoa_o, 0);

      // R3: spread extension, sweep pinned at zero
      ss_en = 1; ss_dev = 0; ss_div_sel = 0;
      tick(); pulse_start();
      high_width(w);
      chk("R3 high width with spread /1", w, 7);
      c = count_o;
      #1 cancel(); @(negedge clk);
      chk("R4 cancel clears start", start_o, 0);
      chk("R4 cancel gives no eoa", eoa_o, 0);
      chk("R6 count held after cancel", count_o, c);
      ss_div_sel = 1; tick(); pulse_start();
      high_width(w);
      chk("R3 high width with spread /2", w, 8);
      #1 cancel();
      ss_dev = 5; tick(); pulse_start();
      repeat (300) tick();
      thresh_hit = 1; tick(); thresh_hit = 0;
      repeat (3) tick();
      ss_en = 0;

      // R8: synchronized start
      sync_mode = 1; sync_pol = 0; sync_in = 1;
      tick(); pulse_start(); repeat (8) tick();
      @(negedge clk);
      chk("R8 waits for falling edge", pulse_o, 0);
      chk("R8 start held while waiting", start_o, 1);
      #1 sync_in = 0; tick(); @(negedge clk);
      chk("R8 falling edge starts run", pulse_o, 1);
      #1 cancel();
      pulse_start(); sync_in = 1; repeat (5) tick();
      @(negedge clk);
      chk("R8 rising edge ignored at pol 0", pulse_o, 0);
      #1 cancel();
      sync_pol = 1;
      pulse_start(); tick(); tick(); @(negedge clk);
      chk("R8 high level starts run at pol 1", pulse_o, 1);
      #1 cancel(); sync_mode = 0; sync_in = 0;

      // R5/R6: ceiling
      hi_len = 0; lo_len = 0; pg_div_sel = 0; maxcnt_sel = 0;
      tick(); pulse_start();
      wait_eoa(2000, seen);
      chk("R7 eoa at ceiling", seen, 1);
      chk("R5 ceiling count 255", count_o, 255);
      chk("R5 error flag set", mce_o, 1);
      #1 pulse_start(); @(negedge clk);
      chk("R5 error cleared on start", mce_o, 0);
      chk("R6 count cleared on start", count_o, 0);
      wait_eoa(2000, seen);
      maxcnt_sel = 7;
      tick(); pulse_start();
      wait_eoa(40000, seen);
      chk("R5 code 7 ceiling 16383", count_o, 16383);
      chk("R5 error flag at largest ceiling", mce_o, 1);

      // R1: disable aborts a run
      maxcnt_sel = 0; tick(); pulse_start(); repeat (10) tick();
      ctl_en = 0; tick(); @(negedge clk);
      chk("R1 disable stops pulses", pulse_o, 0);
      chk("R1 disable clears start", start_o, 0);
      chk("R1 disable gives no eoa", eoa_o, 0);
      chk("R1 disabled io floats", io_float_o, 1);
      repeat (3) tick();
      finish_run();
   end
endmodule